// File: doc/BRIEF.md
# Machine Trap Value Capture

This block owns the machine-level trap value CSR. Whenever the core takes a trap into machine mode it strobes `trap_take` together with the exception code, an interrupt flag, an external-breakpoint flag and three candidate values: the faulting virtual PC, the faulting virtual data address and the instruction encoding. A build-time switch per exception cause decides whether the relevant candidate or zero lands in the CSR. Causes that carry no value, and all interrupts, clear it.

The CSR is physically only `TVAL_W` bits wide. Every write, whether from a trap or from software through the CSR port, keeps only the low `TVAL_W` bits, and reads return them zero-extended to `XLEN`. A trap and a software write in the same cycle resolve in favour of the trap. The width is checked at elaboration against the physical and virtual address widths.

Top module: `tval_capture`

## Requirements
- R1: After reset the CSR reads as zero.
- R2: On an illegal-instruction trap (code 2) the CSR takes the instruction encoding, zero-extended, when `REC_ILLEGAL` is set, and zero otherwise.
- R3: On a breakpoint-instruction trap (code 3) without `ext_brk` the CSR takes the faulting PC when `REC_EBREAK` is set, and zero otherwise.
- R4: A non-interrupt trap with `ext_brk` high always records the faulting PC, whatever the breakpoint switch and the code.
- R5: Fetch access faults (code 1), fetch page faults (code 12) and misaligned fetches (code 0) each record the faulting PC or zero under their own switch.
- R6: Load access faults (code 5), load page faults (code 13), store/AMO access faults (code 7) and store/AMO page faults (code 15) each record the faulting data address or zero under their own switch.
- R7: Misaligned load (code 4) and store/AMO (code 6) traps record the data address or zero under their own switches while `MISAL_IN_HW` is clear; with it set they record zero.
- R8: With `HALFWORD_FETCH` set, a misaligned-fetch trap records zero regardless of its switch.
- R9: Interrupts (`trap_is_irq` high) and codes with no associated value, such as environment calls (8, 9, 11), record zero.
- R10: A software write stores only the low `TVAL_W` bits; reads return them with all higher bits zero.
- R11: When a trap and a software write fall in the same cycle, the trap value is stored.
- R12: With neither a trap nor a software write, the CSR holds its value.
- R13: Elaboration fails unless `TVAL_W` is at least the larger of `PADDR_W` and `VADDR_W` and no more than `XLEN`; the widest virtual address bit survives a trap write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_take | input | 1 | A trap into machine mode is taken this cycle |
| trap_is_irq | input | 1 | The trap is an interrupt |
| ext_brk | input | 1 | The trap is an externally generated breakpoint |
| trap_cause | input | 5 | Exception code |
| fault_pc | input | XLEN | Virtual PC of the trapping instruction |
| fault_addr | input | XLEN | Faulting virtual data address |
| fault_insn | input | ILEN | Encoding of the trapping instruction |
| csr_wr_en | input | 1 | Software write to the CSR |
| csr_wr_data | input | XLEN | Software write data |
| csr_rd_data | output | XLEN | CSR contents, zero-extended |

## Verification
Every exception code is driven into two instances built with different switch settings and widths, so each code separates the PC, address, encoding and zero sources and shows whether its own switch is honoured. Distinct patterns in the PC, address and encoding fields, with bits above the implemented width set, reveal a swapped source or a missing truncation. A marker written before each trap tells a zero result apart from a missed write, and directed cases cover a trap colliding with a software write, idle hold and the top address bit.

// File: rtl/tval_pkg.sv
package tval_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_PC   = 2'd1,
    SRC_ADDR = 2'd2,
    SRC_INSN = 2'd3
  } tval_src_e;

  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] EXC_FETCH_MISAL = 5'd0;
  localparam logic [CAUSE_W-1:0] EXC_FETCH_ACC   = 5'd1;
  localparam logic [CAUSE_W-1:0] EXC_ILLEGAL     = 5'd2;
  localparam logic [CAUSE_W-1:0] EXC_BREAK       = 5'd3;
  localparam logic [CAUSE_W-1:0] EXC_LD_MISAL    = 5'd4;
  localparam logic [CAUSE_W-1:0] EXC_LD_ACC      = 5'd5;
  localparam logic [CAUSE_W-1:0] EXC_ST_MISAL    = 5'd6;
  localparam logic [CAUSE_W-1:0] EXC_ST_ACC      = 5'd7;
  localparam logic [CAUSE_W-1:0] EXC_FETCH_PF    = 5'd12;
  localparam logic [CAUSE_W-1:0] EXC_LD_PF       = 5'd13;
  localparam logic [CAUSE_W-1:0] EXC_ST_PF       = 5'd15;

  // Gate a value source with its per-cause build switch.
  function automatic tval_src_e gate_src(input bit enable, input tval_src_e src);
    return enable ? src : SRC_ZERO;
  endfunction

endpackage

// File: rtl/tval_source_sel.sv
module tval_source_sel
  import tval_pkg::*;
#(
  parameter bit REC_ILLEGAL     = 1'b1,
  parameter bit REC_EBREAK      = 1'b1,
  parameter bit REC_FETCH_MISAL = 1'b1,
  parameter bit REC_FETCH_ACC   = 1'b1,
  parameter bit REC_FETCH_PF    = 1'b1,
  parameter bit REC_LD_MISAL    = 1'b1,
  parameter bit REC_LD_ACC      = 1'b1,
  parameter bit REC_LD_PF       = 1'b1,
  parameter bit REC_ST_MISAL    = 1'b1,
  parameter bit REC_ST_ACC      = 1'b1,
  parameter bit REC_ST_PF       = 1'b1,
  parameter bit HALFWORD_FETCH  = 1'b0,
  parameter bit MISAL_IN_HW     = 1'b0
) (
  input  logic               is_irq,
  input  logic               ext_brk,
  input  logic [CAUSE_W-1:0] cause,
  output tval_src_e          src
);

  // A misaligned fetch cannot happen with halfword fetch alignment (R8).
  localparam bit FETCH_MISAL_ON = REC_FETCH_MISAL && !HALFWORD_FETCH;
  // Misaligned data path only applies without hardware support (R7).
  localparam bit LD_MISAL_ON    = REC_LD_MISAL && !MISAL_IN_HW;
  localparam bit ST_MISAL_ON    = REC_ST_MISAL && !MISAL_IN_HW;

  always_comb begin
    if (is_irq) begin
      src = SRC_ZERO;                       // R9
    end else if (ext_brk) begin
      src = SRC_PC;                         // R4
    end else begin
      case (cause)
        EXC_FETCH_MISAL: src = gate_src(FETCH_MISAL_ON, SRC_PC);
        EXC_FETCH_ACC:   src = gate_src(REC_FETCH_ACC,  SRC_PC);
        EXC_FETCH_PF:    src = gate_src(REC_FETCH_PF,   SRC_PC);
        EXC_ILLEGAL:     src = gate_src(REC_ILLEGAL,    SRC_INSN);
        EXC_BREAK:       src = gate_src(REC_EBREAK,     SRC_PC);
        EXC_LD_MISAL:    src = gate_src(LD_MISAL_ON,    SRC_ADDR);
        EXC_LD_ACC:      src = gate_src(REC_LD_ACC,     SRC_ADDR);
        EXC_LD_PF:       src = gate_src(REC_LD_PF,      SRC_ADDR);
        EXC_ST_MISAL:    src = gate_src(ST_MISAL_ON,    SRC_ADDR);
        EXC_ST_ACC:      src = gate_src(REC_ST_ACC,     SRC_ADDR);
        EXC_ST_PF:       src = gate_src(REC_ST_PF,      SRC_ADDR);
        default:         src = SRC_ZERO;    // R9
      endcase
    end
  end

endmodule

// File: rtl/tval_value_form.sv
module tval_value_form
  import tval_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ILEN   = 32,
  parameter int TVAL_W = 48
) (
  input  tval_src_e         src,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   addr,
  input  logic [ILEN-1:0]   insn,
  output logic [XLEN-1:0]   value
);

  localparam logic [XLEN-1:0] KEEP_MASK = {XLEN{1'b1}} >> (XLEN - TVAL_W);

  function automatic logic [XLEN-1:0] trunc(input logic [XLEN-1:0] x);
    return x & KEEP_MASK;
  endfunction

  logic [XLEN-1:0] raw;

  always_comb begin
    case (src)
      SRC_PC:   raw = pc;
      SRC_ADDR: raw = addr;
      SRC_INSN: raw = XLEN'(insn);
      default:  raw = '0;
    endcase
    value = trunc(raw);
  end

endmodule

// File: rtl/tval_store.sv
module tval_store #(
  parameter int XLEN   = 64,
  parameter int TVAL_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_wr,
  input  logic [XLEN-1:0] trap_val,
  input  logic            sw_wr,
  input  logic [XLEN-1:0] sw_data,
  output logic [XLEN-1:0] q
);

  localparam logic [XLEN-1:0] KEEP_MASK = {XLEN{1'b1}} >> (XLEN - TVAL_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (trap_wr) begin
      q <= trap_val;
    end else if (sw_wr) begin
      q <= sw_data & KEEP_MASK;
    end
  end

endmodule

// File: rtl/tval_capture.sv
module tval_capture
  import tval_pkg::*;
#(
  parameter int XLEN            = 64,
  parameter int ILEN            = 32,
  parameter int TVAL_W          = 48,
  parameter int PADDR_W         = 44,
  parameter int VADDR_W         = 48,
  parameter bit REC_ILLEGAL     = 1'b1,
  parameter bit REC_EBREAK      = 1'b1,
  parameter bit REC_FETCH_MISAL = 1'b1,
  parameter bit REC_FETCH_ACC   = 1'b1,
  parameter bit REC_FETCH_PF    = 1'b1,
  parameter bit REC_LD_MISAL    = 1'b1,
  parameter bit REC_LD_ACC      = 1'b1,
  parameter bit REC_LD_PF       = 1'b1,
  parameter bit REC_ST_MISAL    = 1'b1,
  parameter bit REC_ST_ACC      = 1'b1,
  parameter bit REC_ST_PF       = 1'b1,
  parameter bit HALFWORD_FETCH  = 1'b0,
  parameter bit MISAL_IN_HW     = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_take,
  input  logic               trap_is_irq,
  input  logic               ext_brk,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    fault_pc,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic [ILEN-1:0]    fault_insn,
  input  logic               csr_wr_en,
  input  logic [XLEN-1:0]    csr_wr_data,
  output logic [XLEN-1:0]    csr_rd_data
);

  localparam int ADDR_NEED = (PADDR_W > VADDR_W) ? PADDR_W : VADDR_W;

  // R13: width sanity at elaboration
  if (TVAL_W < ADDR_NEED || TVAL_W > XLEN || ILEN > XLEN) begin : g_width_bad
    $error("tval_capture: TVAL_W must cover the address widths and fit XLEN");
  end

  // Named internal events for the checker
  tval_src_e       trap_src;
  logic [XLEN-1:0] trap_val;
  logic            sw_wr_eff;

  assign sw_wr_eff = csr_wr_en & ~trap_take;   // R11: trap wins

  tval_source_sel #(
    .REC_ILLEGAL    (REC_ILLEGAL),
    .REC_EBREAK     (REC_EBREAK),
    .REC_FETCH_MISAL(REC_FETCH_MISAL),
    .REC_FETCH_ACC  (REC_FETCH_ACC),
    .REC_FETCH_PF   (REC_FETCH_PF),
    .REC_LD_MISAL   (REC_LD_MISAL),
    .REC_LD_ACC     (REC_LD_ACC),
    .REC_LD_PF      (REC_LD_PF),
    .REC_ST_MISAL   (REC_ST_MISAL),
    .REC_ST_ACC     (REC_ST_ACC),
    .REC_ST_PF      (REC_ST_PF),
    .HALFWORD_FETCH (HALFWORD_FETCH),
    .MISAL_IN_HW    (MISAL_IN_HW)
  ) u_sel (
    .is_irq (trap_is_irq),
    .ext_brk(ext_brk),
    .cause  (trap_cause),
    .src    (trap_src)
  );

  tval_value_form #(
    .XLEN  (XLEN),
    .ILEN  (ILEN),
    .TVAL_W(TVAL_W)
  ) u_form (
    .src  (trap_src),
    .pc   (fault_pc),
    .addr (fault_addr),
    .insn (fault_insn),
    .value(trap_val)
  );

  tval_store #(
    .XLEN  (XLEN),
    .TVAL_W(TVAL_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .trap_wr (trap_take),
    .trap_val(trap_val),
    .sw_wr   (sw_wr_eff),
    .sw_data (csr_wr_data),
    .q       (csr_rd_data)
  );

endmodule

// File: rtl/tval_chk.sv
module tval_chk #(
  parameter int XLEN   = 64,
  parameter int TVAL_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_take,
  input logic            trap_is_irq,
  input logic            ext_brk,
  input logic [4:0]      trap_cause,
  input logic [XLEN-1:0] fault_pc,
  input logic            csr_wr_en,
  input logic [XLEN-1:0] csr_wr_data,
  input logic            sw_wr_eff,
  input logic [XLEN-1:0] csr_rd_data
);

  localparam logic [XLEN-1:0] KEEP_MASK = {XLEN{1'b1}} >> (XLEN - TVAL_W);

  // R10
  sw_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_eff |=> csr_rd_data == ($past(csr_wr_data) & KEEP_MASK));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_data & ~KEEP_MASK) == '0);

  // R4
  ext_brk_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && ext_brk && !trap_is_irq |=> csr_rd_data == ($past(fault_pc) & KEEP_MASK));

  // R9
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && trap_is_irq |=> csr_rd_data == '0);

  // R9
  ecall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && !trap_is_irq && !ext_brk && trap_cause == 5'd11 |=> csr_rd_data == '0);

  // R11
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take && csr_wr_en && !trap_is_irq && ext_brk
      |=> csr_rd_data == ($past(fault_pc) & KEEP_MASK));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_take && !csr_wr_en |=> $stable(csr_rd_data));

endmodule

bind tval_capture tval_chk #(
  .XLEN  (XLEN),
  .TVAL_W(TVAL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_take  (trap_take),
  .trap_is_irq(trap_is_irq),
  .ext_brk    (ext_brk),
  .trap_cause (trap_cause),
  .fault_pc   (fault_pc),
  .csr_wr_en  (csr_wr_en),
  .csr_wr_data(csr_wr_data),
  .sw_wr_eff  (sw_wr_eff),
  .csr_rd_data(csr_rd_data)
);

// File: tb/tval_capture_bench.sv
module tval_capture_bench;

  typedef struct packed {
    logic        irq;
    logic        ext;
    logic [4:0]  cause;
    logic [63:0] pc;
    logic [63:0] addr;
    logic [31:0] insn;
  } vec_t;

  localparam logic [63:0] MAIN_MASK = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [63:0] ALT_MASK  = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [63:0] MARKER    = 64'h0000_0011_2233_4455;
  localparam int NVEC = 15;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 5'd0,  64'hFF00_8000_0000_1002, 64'hAA00_0000_0000_0001, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd1,  64'hEE11_8000_0000_2004, 64'hAA00_0000_0000_0002, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd2,  64'hDD22_8000_0000_3008, 64'hAA00_0000_0000_0003, 32'hC0DE_1073},
    '{1'b0, 1'b0, 5'd3,  64'hCC33_8000_0000_400C, 64'hAA00_0000_0000_0004, 32'h0010_0073},
    '{1'b0, 1'b0, 5'd4,  64'h0000_0000_0000_5000, 64'hBB44_1234_5678_9AB1, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd5,  64'h0000_0000_0000_6000, 64'hCC55_2345_6789_ABC0, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd6,  64'h0000_0000_0000_7000, 64'hDD66_3456_789A_BCD3, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd7,  64'h0000_0000_0000_8000, 64'hEE77_4567_89AB_CDE8, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd12, 64'hBB44_0000_ABCD_9000, 64'hAA00_0000_0000_0005, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd13, 64'h0000_0000_0000_A000, 64'hFF88_5678_9ABC_DEF0, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd15, 64'h0000_0000_0000_B000, 64'h1199_6789_ABCD_EF08, 32'h0000_0013},
    '{1'b0, 1'b0, 5'd8,  64'h7777_0000_0000_C000, 64'h7777_0000_0000_0006, 32'h0000_0073},
    '{1'b0, 1'b0, 5'd11, 64'h6666_0000_0000_D000, 64'h6666_0000_0000_0007, 32'h0000_0073},
    '{1'b1, 1'b0, 5'd7,  64'h5555_0000_0000_E000, 64'h5555_0000_0000_0008, 32'h0000_0013},
    '{1'b0, 1'b1, 5'd3,  64'h4444_9876_5432_F000, 64'h4444_0000_0000_0009, 32'h0000_0013}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_take = 1'b0;
  logic        trap_is_irq = 1'b0;
  logic        ext_brk = 1'b0;
  logic [4:0]  trap_cause = '0;
  logic [63:0] fault_pc = '0;
  logic [63:0] fault_addr = '0;
  logic [31:0] fault_insn = '0;
  logic        csr_wr_en = 1'b0;
  logic [63:0] csr_wr_data = '0;
  logic [63:0] rd_main;
  logic [63:0] rd_alt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tval_capture u_tval_capture (
    .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
    .ext_brk(ext_brk), .trap_cause(trap_cause), .fault_pc(fault_pc),
    .fault_addr(fault_addr), .fault_insn(fault_insn), .csr_wr_en(csr_wr_en),
    .csr_wr_data(csr_wr_data), .csr_rd_data(rd_main)
  );

  tval_capture #(
    .TVAL_W(40), .PADDR_W(34), .VADDR_W(39),
    .REC_ILLEGAL(1'b0), .REC_EBREAK(1'b0), .REC_LD_ACC(1'b0),
    .REC_ST_PF(1'b0), .REC_FETCH_PF(1'b0),
    .HALFWORD_FETCH(1'b1), .MISAL_IN_HW(1'b1)
  ) u_tval_capture_alt (
    .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
    .ext_brk(ext_brk), .trap_cause(trap_cause), .fault_pc(fault_pc),
    .fault_addr(fault_addr), .fault_insn(fault_insn), .csr_wr_en(csr_wr_en),
    .csr_wr_data(csr_wr_data), .csr_rd_data(rd_alt)
  );

  // Default build: every switch on, full-width fetch, no hardware misaligned support.
  function automatic logic [63:0] exp_main(input vec_t v);
    logic [63:0] r;
    if (v.irq) r = '0;
    else if (v.ext) r = v.pc;
    else case (v.cause)
      5'd0, 5'd1, 5'd3, 5'd12:         r = v.pc;
      5'd2:                            r = {32'h0, v.insn};
      5'd4, 5'd5, 5'd6, 5'd7, 5'd13, 5'd15: r = v.addr;
      default:                         r = '0;
    endcase
    return r & MAIN_MASK;
  endfunction

  // Alternate build: several switches off, halfword fetch, hardware misaligned support.
  function automatic logic [63:0] exp_alt(input vec_t v);
    logic [63:0] r;
    if (v.irq) r = '0;
    else if (v.ext) r = v.pc;
    else case (v.cause)
      5'd1:         r = v.pc;
      5'd7, 5'd13:  r = v.addr;
      default:      r = '0;
    endcase
    return r & ALT_MASK;
  endfunction

  function automatic string req_of(input vec_t v);
    if (v.irq) return "R9";
    if (v.ext) return "R4";
    case (v.cause)
      5'd0:                      return "R5 R8";
      5'd1, 5'd12:               return "R5";
      5'd2:                      return "R2";
      5'd3:                      return "R3";
      5'd4, 5'd6:                return "R7";
      5'd5, 5'd7, 5'd13, 5'd15:  return "R6";
      default:                   return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_trap(input vec_t v, input logic also_write, input logic [63:0] wdata);
    trap_take   = 1'b1;
    trap_is_irq = v.irq;
    ext_brk     = v.ext;
    trap_cause  = v.cause;
    fault_pc    = v.pc;
    fault_addr  = v.addr;
    fault_insn  = v.insn;
    csr_wr_en   = also_write;
    csr_wr_data = wdata;
    @(negedge clk);
    trap_take = 1'b0;
    csr_wr_en = 1'b0;
  endtask

  task automatic sw_write(input logic [63:0] d);
    csr_wr_en   = 1'b1;
    csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 main reset", rd_main, 64'h0);
    check("R1 alt reset", rd_alt, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      sw_write(MARKER);
      drive_trap(VECS[i], 1'b0, 64'h0);
      check({req_of(VECS[i]), " main"}, rd_main, exp_main(VECS[i]));
      check({req_of(VECS[i]), " alt"}, rd_alt, exp_alt(VECS[i]));
    end

    // R10: all-ones write keeps only the implemented bits
    sw_write(64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 main truncation", rd_main, MAIN_MASK);
    check("R10 alt truncation", rd_alt, ALT_MASK);

    // R12: idle cycles with changing write data but no enable
    csr_wr_data = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    csr_wr_data = 64'h0;
    @(negedge clk);
    check("R12 main hold", rd_main, MAIN_MASK);
    check("R12 alt hold", rd_alt, ALT_MASK);

    // R11: trap (load access fault) and software write in the same cycle
    v = '{1'b0, 1'b0, 5'd5, 64'h0, 64'h0000_7654_3210_FEDC, 32'h0};
    drive_trap(v, 1'b1, 64'h0000_0000_DEAD_BEEF);
    check("R11 main trap wins", rd_main, 64'h0000_7654_3210_FEDC);
    check("R11 alt trap wins", rd_alt, 64'h0);

    // R13: top virtual address bit survives a trap write
    v = '{1'b0, 1'b0, 5'd13, 64'h0, 64'hFFFF_8000_0000_0000, 32'h0};
    drive_trap(v, 1'b0, 64'h0);
    check("R13 main top bit", rd_main, 64'h0000_8000_0000_0000);
    v = '{1'b0, 1'b0, 5'd13, 64'h0, 64'hFFFF_FF40_0000_0000, 32'h0};
    drive_trap(v, 1'b0, 64'h0);
    check("R13 alt top bit", rd_alt, 64'h0000_0040_0000_0000);

    // R1: reset clears a non-zero value
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 main re-reset", rd_main, 64'h0);
    check("R1 alt re-reset", rd_alt, 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule